// File: doc/BRIEF.md
# Configurable Snooping Line-State Controller

This block decides how one cache line of a snooping cache changes its coherence state. Each request names the line's present state, the channel it came on (local processor, bus response to one of this cache's own requests, or a snooped transaction from another agent) and a command code. One clock later the block returns the line's next state, the bus command the cache must issue, whether this cache must drive the line's data onto the bus, whether it must raise the shared wire, and an error flag. The error flag marks a state and command pair that the selected protocol does not allow.

Two parameters pick the variant. `PROTO` selects the protocol: 0 = MSI, 1 = MESI, 2 = MOSI, 3 = MOESI. `UPGRADES` chooses whether a write to a line that is present but not writable issues a data-less upgrade or a full read-exclusive. A state is three status bits, so the tag store can keep the block's result as it is. Tag lookup, data storage, miss tracking and arbitration belong to the surrounding cache.

Top module: `coh_line_ctrl`

## Requirements
- R1: The state is `curState[2:0]` = {valid, writable, dirty}: Invalid 3'b000, Shared 3'b100, Owned 3'b101, Exclusive 3'b110, Modified 3'b111. An encoding that the selected protocol lacks raises `illegal`. Owned exists only for PROTO 2 and 3, Exclusive only for PROTO 1 and 3, and 3'b001, 3'b010 and 3'b011 never exist.
- R2: Processor channel (`reqChan`=0), with commands 0 read, 1 write, 2 software prefetch and 3 hardware prefetch. Read or either prefetch to Invalid issues bus read (`busCmd`=1). Write to Invalid issues read-exclusive (`busCmd`=2). In both cases the state stays Invalid. A read to any valid line, or a write to Modified, issues nothing and keeps the state. A write to Exclusive moves the line to Modified with no bus command. A prefetch to a valid line is illegal.
- R3: A processor write to Shared, or to Owned, keeps the state. It issues upgrade (`busCmd`=3) when UPGRADES=1 and read-exclusive (`busCmd`=2) otherwise.
- R4: Response channel (`reqChan`=1), with commands 0 read data, 1 exclusive data and 2 upgrade grant. Read data to Invalid gives Exclusive in protocols with Exclusive, or Shared if `sharedSeen`=1. In the other protocols it gives Shared. Exclusive data to Invalid gives Modified. The write-to-shared completion (upgrade grant when UPGRADES=1, exclusive data otherwise) moves Shared or Owned to Modified. The mismatched completion is illegal.
- R5: Snoop channel (`reqChan`=2), with commands 0 read, 1 read-exclusive, 2 upgrade, 3 invalidate and 4 write-invalidate. A snooped read to Modified sets `supplyData` and moves the line to Owned, or to Shared in protocols without Owned. A snooped read to Owned sets `supplyData` and the line stays Owned.
- R6: A snooped read-exclusive to Modified or Owned sets `supplyData` and moves the line to Invalid. To Shared or Exclusive it moves the line to Invalid without supplying data.
- R7: A snooped read to Shared or Exclusive raises `assertShared` only in protocols with Exclusive, and the line ends Shared. In MSI and MOSI a snooped read to Shared does nothing.
- R8: A snooped invalidate or write-invalidate moves any legal state to Invalid. A snooped upgrade moves Shared or Owned to Invalid. Snooped read, read-exclusive and upgrade leave Invalid unchanged. A snooped upgrade is illegal when UPGRADES=0, and also against Exclusive or Modified.
- R9: With an Owned protocol and UPGRADES=0, every request is illegal. Command or channel codes outside the lists above are illegal. An illegal result keeps the state, issues no bus command and clears both flags.
- R10: Results are registered. `outValid` is high exactly one cycle after `reqValid`. Without a request, all result outputs hold their last value. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqChan | input | 2 | 0 processor, 1 bus response, 2 snoop |
| reqCmd | input | 3 | Command code, meaning depends on channel |
| curState | input | 3 | Present line state {valid, writable, dirty} |
| sharedSeen | input | 1 | Shared wire was raised during this fill |
| outValid | output | 1 | Result registers updated last cycle |
| nextState | output | 3 | State to write back to the tag |
| busCmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 upgrade |
| supplyData | output | 1 | This cache must drive the line data |
| assertShared | output | 1 | Raise the shared wire |
| illegal | output | 1 | Pair not permitted by the protocol |

## Verification
The assertions assume `curState` and the command fields are stable and known whenever `reqValid` is high. They also assume that the `curState` sampled at the capture edge is the state the result refers to, because several properties compare the output with `$past(curState)`. The bench drives every input on the falling edge, holds it through the rising edge, and never leaves `reqValid` high with undriven fields. It deliberately presents undefined state encodings, codes outside the lists, and pairs the protocol does not allow, because these are legal stimulus that must end in `illegal`.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int STATE_W = 3;
  localparam int CMD_W   = 3;
  localparam int CHAN_W  = 2;
  localparam int BUS_W   = 2;

  // status bit positions inside a state
  localparam int BIT_V = 2;
  localparam int BIT_W = 1;
  localparam int BIT_D = 0;

  localparam logic [STATE_W-1:0] ST_INV = 3'b000;
  localparam logic [STATE_W-1:0] ST_SHR = 3'b100;
  localparam logic [STATE_W-1:0] ST_OWN = 3'b101;
  localparam logic [STATE_W-1:0] ST_EXC = 3'b110;
  localparam logic [STATE_W-1:0] ST_MOD = 3'b111;

  localparam logic [CHAN_W-1:0] CH_PROC  = 2'd0;
  localparam logic [CHAN_W-1:0] CH_RESP  = 2'd1;
  localparam logic [CHAN_W-1:0] CH_SNOOP = 2'd2;

  // processor commands
  localparam logic [CMD_W-1:0] PC_READ  = 3'd0;
  localparam logic [CMD_W-1:0] PC_WRITE = 3'd1;
  localparam logic [CMD_W-1:0] PC_SWPF  = 3'd2;
  localparam logic [CMD_W-1:0] PC_HWPF  = 3'd3;
  // response commands
  localparam logic [CMD_W-1:0] RC_DATA  = 3'd0;
  localparam logic [CMD_W-1:0] RC_XDATA = 3'd1;
  localparam logic [CMD_W-1:0] RC_GRANT = 3'd2;
  // snoop commands
  localparam logic [CMD_W-1:0] SC_READ  = 3'd0;
  localparam logic [CMD_W-1:0] SC_RDX   = 3'd1;
  localparam logic [CMD_W-1:0] SC_UPG   = 3'd2;
  localparam logic [CMD_W-1:0] SC_INV   = 3'd3;
  localparam logic [CMD_W-1:0] SC_WINV  = 3'd4;

  localparam logic [BUS_W-1:0] BUS_NONE = 2'd0;
  localparam logic [BUS_W-1:0] BUS_RD   = 2'd1;
  localparam logic [BUS_W-1:0] BUS_RDX  = 2'd2;
  localparam logic [BUS_W-1:0] BUS_UPG  = 2'd3;

  // strobes from the decode control to the result datapath
  typedef struct packed {
    logic toInv;
    logic toShr;
    logic toExc;
    logic toMod;
    logic toOwn;
    logic keep;
    logic fault;
    logic issueRd;
    logic issueRdx;
    logic issueUpg;
    logic supply;
    logic share;
  } cohStrobe_t;
endpackage

// File: rtl/coh_decode.sv
module coh_decode
  import coh_pkg::*;
#(
  parameter bit HAS_OWN = 1'b1,
  parameter bit HAS_EXC = 1'b1,
  parameter bit UPGRADES = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CHAN_W-1:0]  reqChan,
  input  logic [CMD_W-1:0]   reqCmd,
  input  logic [STATE_W-1:0] curState,
  input  logic               sharedSeen,
  output cohStrobe_t         strobe
);
  localparam bit CFG_OK = !(HAS_OWN && !UPGRADES);

  logic known;
  logic isShr, isOwn, isExc, isMod, isInv;

  always_comb begin
    isInv = (curState == ST_INV);
    isShr = (curState == ST_SHR);
    isMod = (curState == ST_MOD);
    isOwn = HAS_OWN && (curState == ST_OWN);
    isExc = HAS_EXC && (curState == ST_EXC);
    known = isInv || isShr || isMod || isOwn || isExc;
  end

  always_comb begin
    strobe = '0;
    if (!CFG_OK || !known) begin
      strobe.fault = 1'b1;
    end else begin
      case (reqChan)
        CH_PROC: begin
          case (reqCmd)
            PC_READ: begin
              strobe.keep = 1'b1;
              strobe.issueRd = isInv;
            end
            PC_WRITE: begin
              if (isInv) begin
                strobe.keep = 1'b1;
                strobe.issueRdx = 1'b1;
              end else if (isShr || isOwn) begin
                strobe.keep = 1'b1;
                strobe.issueUpg = UPGRADES;
                strobe.issueRdx = !UPGRADES;
              end else if (isExc) begin
                strobe.toMod = 1'b1;
              end else begin
                strobe.keep = 1'b1;
              end
            end
            PC_SWPF, PC_HWPF: begin
              if (isInv) begin
                strobe.keep = 1'b1;
                strobe.issueRd = 1'b1;
              end else begin
                strobe.fault = 1'b1;
              end
            end
            default: strobe.fault = 1'b1;
          endcase
        end
        CH_RESP: begin
          case (reqCmd)
            RC_DATA: begin
              if (isInv) begin
                if (HAS_EXC && !sharedSeen) strobe.toExc = 1'b1;
                else                        strobe.toShr = 1'b1;
              end else strobe.fault = 1'b1;
            end
            RC_XDATA: begin
              if (isInv || (!UPGRADES && (isShr || isOwn))) strobe.toMod = 1'b1;
              else strobe.fault = 1'b1;
            end
            RC_GRANT: begin
              if (UPGRADES && (isShr || isOwn)) strobe.toMod = 1'b1;
              else strobe.fault = 1'b1;
            end
            default: strobe.fault = 1'b1;
          endcase
        end
        CH_SNOOP: begin
          case (reqCmd)
            SC_READ: begin
              if (isMod) begin
                strobe.supply = 1'b1;
                strobe.toOwn = HAS_OWN;
                strobe.toShr = !HAS_OWN;
              end else if (isOwn) begin
                strobe.supply = 1'b1;
                strobe.keep = 1'b1;
              end else if (isShr || isExc) begin
                strobe.share = HAS_EXC;
                strobe.toShr = 1'b1;
              end else begin
                strobe.keep = 1'b1;
              end
            end
            SC_RDX: begin
              strobe.supply = isMod || isOwn;
              strobe.toInv = 1'b1;
            end
            SC_UPG: begin
              if (UPGRADES && (isInv || isShr || isOwn)) strobe.toInv = 1'b1;
              else strobe.fault = 1'b1;
            end
            SC_INV, SC_WINV: strobe.toInv = 1'b1;
            default: strobe.fault = 1'b1;
          endcase
        end
        default: strobe.fault = 1'b1;
      endcase
    end
  end

  // exactly one destination choice per decode (R1)
  assert_one_dest_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot({strobe.toInv, strobe.toShr, strobe.toExc,
                          strobe.toMod, strobe.toOwn, strobe.keep, strobe.fault}));

  // undefined encodings never decode to a transition (R1)
  assert_bad_encoding_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curState != ST_INV && !curState[BIT_V]) |-> strobe.fault);

  // at most one bus command and no data supply while a command is issued (R2)
  assert_one_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot0({strobe.issueRd, strobe.issueRdx, strobe.issueUpg, strobe.supply}));
endmodule

// File: rtl/coh_result.sv
module coh_result
  import coh_pkg::*;
#(
  parameter bit HAS_OWN = 1'b1,
  parameter bit HAS_EXC = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [STATE_W-1:0] curState,
  input  cohStrobe_t         strobe,
  output logic               outValid,
  output logic [STATE_W-1:0] nextState,
  output logic [BUS_W-1:0]   busCmd,
  output logic               supplyData,
  output logic               assertShared,
  output logic               illegal
);
  logic [STATE_W-1:0] stateD;
  logic [BUS_W-1:0]   busD;

  always_comb begin
    if (strobe.keep || strobe.fault) begin
      stateD = curState;
    end else begin
      stateD[BIT_V] = !strobe.toInv;
      stateD[BIT_W] = strobe.toExc || strobe.toMod;
      stateD[BIT_D] = strobe.toMod || strobe.toOwn;
    end
    if (strobe.fault)         busD = BUS_NONE;
    else if (strobe.issueUpg) busD = BUS_UPG;
    else if (strobe.issueRdx) busD = BUS_RDX;
    else if (strobe.issueRd)  busD = BUS_RD;
    else                      busD = BUS_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      nextState    <= '0;
      busCmd       <= BUS_NONE;
      supplyData   <= 1'b0;
      assertShared <= 1'b0;
      illegal      <= 1'b0;
    end else begin
      outValid <= reqValid;
      if (reqValid) begin
        nextState    <= stateD;
        busCmd       <= busD;
        supplyData   <= strobe.supply && !strobe.fault;
        assertShared <= strobe.share && !strobe.fault;
        illegal      <= strobe.fault;
      end
    end
  end

  // a bus command never changes the line at once (R2)
  assert_issue_keeps_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && busCmd != BUS_NONE) |-> nextState == $past(curState));

  // supplying data leaves the line Owned or Invalid (R5)
  assert_supply_dest_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && supplyData) |-> (nextState == ST_OWN || nextState == ST_INV ||
                                  (!HAS_OWN && nextState == ST_SHR)));

  // shared wire only with an Exclusive protocol, line ends Shared (R7)
  assert_share_only_exc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && assertShared) |-> (HAS_EXC && nextState == ST_SHR && !supplyData));

  // illegal result is inert (R9)
  assert_fault_inert_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegal) |-> (nextState == $past(curState) && busCmd == BUS_NONE &&
                               !supplyData && !assertShared));

  // one-cycle latency and hold (R10)
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && $stable(nextState) && $stable(busCmd)));
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int PROTO    = 3,
  parameter bit UPGRADES = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CHAN_W-1:0]  reqChan,
  input  logic [CMD_W-1:0]   reqCmd,
  input  logic [STATE_W-1:0] curState,
  input  logic               sharedSeen,
  output logic               outValid,
  output logic [STATE_W-1:0] nextState,
  output logic [BUS_W-1:0]   busCmd,
  output logic               supplyData,
  output logic               assertShared,
  output logic               illegal
);
  localparam bit HAS_EXC = (PROTO == 1) || (PROTO == 3);
  localparam bit HAS_OWN = (PROTO == 2) || (PROTO == 3);

  cohStrobe_t strobe;

  coh_decode #(.HAS_OWN(HAS_OWN), .HAS_EXC(HAS_EXC), .UPGRADES(UPGRADES)) uDecode (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .reqCmd(reqCmd), .curState(curState), .sharedSeen(sharedSeen), .strobe(strobe)
  );

  coh_result #(.HAS_OWN(HAS_OWN), .HAS_EXC(HAS_EXC)) uResult (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .curState(curState), .strobe(strobe),
    .outValid(outValid), .nextState(nextState), .busCmd(busCmd),
    .supplyData(supplyData), .assertShared(assertShared), .illegal(illegal)
  );
endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
  localparam int NI = 5;  // 0 MSI/noUpg, 1 MESI, 2 MOSI, 3 MOESI (uut), 4 MOSI/noUpg
  localparam logic [2:0] SI = 3'b000, SS = 3'b100, SO = 3'b101, SE = 3'b110, SM = 3'b111;
  localparam logic [1:0] CP = 2'd0, CR = 2'd1, CN = 2'd2;

  typedef struct packed {
    logic [3:0] req; logic [2:0] inst; logic [1:0] chan; logic [2:0] cmd;
    logic [2:0] st; logic shr; logic [2:0] eNext; logic [1:0] eBus;
    logic eSup; logic eShr; logic eErr;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 3'd3, CP, 3'd0, SI, 1'b0, SI, 2'd1, 1'b0, 1'b0, 1'b0}, // R2 read miss
    '{4'd2, 3'd3, CP, 3'd1, SI, 1'b0, SI, 2'd2, 1'b0, 1'b0, 1'b0}, // R2 write miss
    '{4'd2, 3'd3, CP, 3'd2, SI, 1'b0, SI, 2'd1, 1'b0, 1'b0, 1'b0}, // R2 sw prefetch
    '{4'd2, 3'd3, CP, 3'd3, SI, 1'b0, SI, 2'd1, 1'b0, 1'b0, 1'b0}, // R2 hw prefetch
    '{4'd2, 3'd3, CP, 3'd1, SE, 1'b0, SM, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 silent E->M
    '{4'd2, 3'd3, CP, 3'd0, SM, 1'b0, SM, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 read hit
    '{4'd2, 3'd3, CP, 3'd0, SO, 1'b0, SO, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 read hit O
    '{4'd2, 3'd3, CP, 3'd1, SM, 1'b0, SM, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 write hit M
    '{4'd2, 3'd3, CP, 3'd2, SS, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b1}, // R2 prefetch hit illegal
    '{4'd3, 3'd3, CP, 3'd1, SS, 1'b0, SS, 2'd3, 1'b0, 1'b0, 1'b0}, // R3 upgrade from S
    '{4'd3, 3'd3, CP, 3'd1, SO, 1'b0, SO, 2'd3, 1'b0, 1'b0, 1'b0}, // R3 upgrade from O
    '{4'd3, 3'd0, CP, 3'd1, SS, 1'b0, SS, 2'd2, 1'b0, 1'b0, 1'b0}, // R3 no upgrades -> rdx
    '{4'd1, 3'd0, CP, 3'd1, SO, 1'b0, SO, 2'd0, 1'b0, 1'b0, 1'b1}, // R1 MSI has no O
    '{4'd1, 3'd1, CP, 3'd0, SO, 1'b0, SO, 2'd0, 1'b0, 1'b0, 1'b1}, // R1 MESI has no O
    '{4'd1, 3'd2, CN, 3'd0, SE, 1'b0, SE, 2'd0, 1'b0, 1'b0, 1'b1}, // R1 MOSI has no E
    '{4'd1, 3'd3, CP, 3'd0, 3'b011, 1'b0, 3'b011, 2'd0, 1'b0, 1'b0, 1'b1}, // R1 undefined
    '{4'd1, 3'd3, CN, 3'd3, 3'b001, 1'b0, 3'b001, 2'd0, 1'b0, 1'b0, 1'b1}, // R1 undefined
    '{4'd4, 3'd3, CR, 3'd0, SI, 1'b0, SE, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 fill E
    '{4'd4, 3'd3, CR, 3'd0, SI, 1'b1, SS, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 fill shared
    '{4'd4, 3'd0, CR, 3'd0, SI, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 MSI fill S
    '{4'd4, 3'd2, CR, 3'd0, SI, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 MOSI fill S
    '{4'd4, 3'd3, CR, 3'd1, SI, 1'b0, SM, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 xdata -> M
    '{4'd4, 3'd3, CR, 3'd2, SS, 1'b0, SM, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 grant S -> M
    '{4'd4, 3'd3, CR, 3'd2, SO, 1'b0, SM, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 grant O -> M
    '{4'd4, 3'd0, CR, 3'd1, SS, 1'b0, SM, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 MSI xdata S -> M
    '{4'd4, 3'd0, CR, 3'd2, SS, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b1}, // R4 grant w/o upgrades
    '{4'd4, 3'd3, CR, 3'd1, SS, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b1}, // R4 mismatched completion
    '{4'd5, 3'd3, CN, 3'd0, SM, 1'b0, SO, 2'd0, 1'b1, 1'b0, 1'b0}, // R5 M -> O supply
    '{4'd5, 3'd1, CN, 3'd0, SM, 1'b0, SS, 2'd0, 1'b1, 1'b0, 1'b0}, // R5 MESI M -> S
    '{4'd5, 3'd3, CN, 3'd0, SO, 1'b0, SO, 2'd0, 1'b1, 1'b0, 1'b0}, // R5 O stays, supply
    '{4'd6, 3'd3, CN, 3'd1, SM, 1'b0, SI, 2'd0, 1'b1, 1'b0, 1'b0}, // R6 M rdx
    '{4'd6, 3'd2, CN, 3'd1, SO, 1'b0, SI, 2'd0, 1'b1, 1'b0, 1'b0}, // R6 O rdx
    '{4'd6, 3'd3, CN, 3'd1, SS, 1'b0, SI, 2'd0, 1'b0, 1'b0, 1'b0}, // R6 S rdx
    '{4'd6, 3'd3, CN, 3'd1, SE, 1'b0, SI, 2'd0, 1'b0, 1'b0, 1'b0}, // R6 E rdx
    '{4'd7, 3'd3, CN, 3'd0, SS, 1'b0, SS, 2'd0, 1'b0, 1'b1, 1'b0}, // R7 S shared
    '{4'd7, 3'd1, CN, 3'd0, SE, 1'b0, SS, 2'd0, 1'b0, 1'b1, 1'b0}, // R7 E shared
    '{4'd7, 3'd0, CN, 3'd0, SS, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 MSI quiet
    '{4'd7, 3'd2, CN, 3'd0, SS, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 MOSI quiet
    '{4'd8, 3'd3, CN, 3'd2, SS, 1'b0, SI, 2'd0, 1'b0, 1'b0, 1'b0}, // R8 upg S
    '{4'd8, 3'd3, CN, 3'd2, SO, 1'b0, SI, 2'd0, 1'b0, 1'b0, 1'b0}, // R8 upg O
    '{4'd8, 3'd3, CN, 3'd3, SM, 1'b0, SI, 2'd0, 1'b0, 1'b0, 1'b0}, // R8 inv M
    '{4'd8, 3'd1, CN, 3'd4, SE, 1'b0, SI, 2'd0, 1'b0, 1'b0, 1'b0}, // R8 winv E
    '{4'd8, 3'd3, CN, 3'd0, SI, 1'b0, SI, 2'd0, 1'b0, 1'b0, 1'b0}, // R8 read on I
    '{4'd8, 3'd3, CN, 3'd2, SM, 1'b0, SM, 2'd0, 1'b0, 1'b0, 1'b1}, // R8 upg on M illegal
    '{4'd9, 3'd4, CP, 3'd0, SI, 1'b0, SI, 2'd0, 1'b0, 1'b0, 1'b1}, // R9 bad configuration
    '{4'd9, 3'd3, CN, 3'd7, SS, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b1}  // R9 unknown command
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqChan = '0;
  logic [2:0] reqCmd = '0;
  logic [2:0] curState = '0;
  logic sharedSeen = 1'b0;
  logic       oValid [NI];
  logic [2:0] oNext  [NI];
  logic [1:0] oBus   [NI];
  logic       oSup   [NI];
  logic       oShr   [NI];
  logic       oErr   [NI];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  coh_line_ctrl #(.PROTO(0), .UPGRADES(1'b0)) uMsi (.clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqChan(reqChan), .reqCmd(reqCmd), .curState(curState), .sharedSeen(sharedSeen),
    .outValid(oValid[0]), .nextState(oNext[0]), .busCmd(oBus[0]), .supplyData(oSup[0]),
    .assertShared(oShr[0]), .illegal(oErr[0]));
  coh_line_ctrl #(.PROTO(1), .UPGRADES(1'b1)) uMesi (.clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqChan(reqChan), .reqCmd(reqCmd), .curState(curState), .sharedSeen(sharedSeen),
    .outValid(oValid[1]), .nextState(oNext[1]), .busCmd(oBus[1]), .supplyData(oSup[1]),
    .assertShared(oShr[1]), .illegal(oErr[1]));
  coh_line_ctrl #(.PROTO(2), .UPGRADES(1'b1)) uMosi (.clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqChan(reqChan), .reqCmd(reqCmd), .curState(curState), .sharedSeen(sharedSeen),
    .outValid(oValid[2]), .nextState(oNext[2]), .busCmd(oBus[2]), .supplyData(oSup[2]),
    .assertShared(oShr[2]), .illegal(oErr[2]));
  coh_line_ctrl #(.PROTO(3), .UPGRADES(1'b1)) uut (.clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqChan(reqChan), .reqCmd(reqCmd), .curState(curState), .sharedSeen(sharedSeen),
    .outValid(oValid[3]), .nextState(oNext[3]), .busCmd(oBus[3]), .supplyData(oSup[3]),
    .assertShared(oShr[3]), .illegal(oErr[3]));
  coh_line_ctrl #(.PROTO(2), .UPGRADES(1'b0)) uBadCfg (.clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqChan(reqChan), .reqCmd(reqCmd), .curState(curState), .sharedSeen(sharedSeen),
    .outValid(oValid[4]), .nextState(oNext[4]), .busCmd(oBus[4]), .supplyData(oSup[4]),
    .assertShared(oShr[4]), .illegal(oErr[4]));

  task automatic check(input string tag, input int idx, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s inst=%0d act={v,state,bus,sup,shr,err}=%b exp=%b", tag, idx, act, exp);
    end
  endtask

  function automatic logic [9:0] packOut(input int i);
    return {1'b0, oValid[i], oNext[i], oBus[i], oSup[i], oShr[i], oErr[i]};
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired before the run ended");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NI; i++) check("R10 reset", i, packOut(i), 10'd0);
    @(negedge clk) rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqChan = VECS[k].chan; reqCmd = VECS[k].cmd;
      curState = VECS[k].st; sharedSeen = VECS[k].shr;
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].inst, packOut(VECS[k].inst),
            {1'b0, 1'b1, VECS[k].eNext, VECS[k].eBus, VECS[k].eSup, VECS[k].eShr, VECS[k].eErr});
      @(negedge clk) reqValid = 1'b0;
    end

    // R10: idle cycle drops outValid, results hold; inputs change meanwhile
    @(negedge clk);
    reqChan = CN; reqCmd = 3'd3; curState = SM;
    @(posedge clk); #1;
    check("R10 hold", 3, packOut(3), {1'b0, 1'b0, SS, 2'd0, 1'b0, 1'b0, 1'b1});

    // R9: bad configuration rejects a snoop invalidate too
    @(negedge clk) reqValid = 1'b1;
    @(posedge clk); #1;
    check("R9 bad cfg snoop", 4, packOut(4), {1'b0, 1'b1, SM, 2'd0, 1'b0, 1'b0, 1'b1});
    check("R8 inv M on MSI", 0, packOut(0), {1'b0, 1'b1, SI, 2'd0, 1'b0, 1'b0, 1'b0});

    // R10: back-to-back requests, each result one cycle later
    @(negedge clk); reqChan = CP; reqCmd = 3'd1; curState = SI;
    @(posedge clk); #1;
    check("R10 back-to-back", 3, packOut(3), {1'b0, 1'b1, SI, 2'd2, 1'b0, 1'b0, 1'b0});
    @(negedge clk) reqValid = 1'b0;
    @(posedge clk); #1;
    check("R10 drop", 3, {9'd0, oValid[3]}, 10'd0);

    // R10: reset mid-run clears outputs
    @(negedge clk) rstN = 1'b0;
    @(posedge clk); #1;
    check("R10 reset again", 3, packOut(3), 10'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule